// File: doc/BRIEF.md
# Compact Branch Resolver

This block takes one 32-bit instruction word from the compact (no delay slot) branch family, together with the values of its two source registers, the current program counter and a flag that says the word sits in a delay slot. In one registered stage it works out whether the word is a compact branch at all, whether the branch is taken, where it goes, whether the return address must be written to register 31, and whether the word must raise a reserved-instruction exception. A word that is not a compact branch is flagged so that the ordinary decoder can take it.

Several branches share each major opcode. The block tells them apart by comparing the two register-number fields with each other and with zero. The condition can be a test of one register against zero, a signed or unsigned compare of two registers, equality, or a signed 32-bit add overflow check. Targets are program-counter-relative with three offset widths, or register-relative for the two jump forms. On a wide datapath an address-wrap input folds the target back into the sign-extended 32-bit range.

Top module: `cbr_resolve`

## Requirements
- R1: Every output is registered. One cycle after `valid_i` is high, `out_valid_o` is high and the flags describe that word. After a cycle with `valid_i` low, `out_valid_o`, `taken_o`, `link_we_o`, `ri_exc_o` and `not_cbr_o` are all low, which is also their state after reset.
- R2: Fields are opcode = bits 31:26, rs number = bits 25:21, rt number = bits 20:16, imm16 = bits 15:0. Opcodes 0x06, 0x07, 0x08, 0x16, 0x17, 0x18, 0x32, 0x36, 0x3A and 0x3E are compact branches. Any other opcode, and opcode 0x06 or 0x07 with rt number 0, sets `not_cbr_o` with no taken, link or exception.
- R3: For opcodes 0x06, 0x07, 0x16 and 0x17 with rt number nonzero: rs number 0 tests rt value signed <= 0 (0x06, 0x16) or > 0 (0x07, 0x17); rs number equal to rt number tests rt value >= 0 (0x06, 0x16) or < 0 (0x07, 0x17); otherwise rs value is compared with rt value, >= (0x06, 0x16) or < (0x07, 0x17), unsigned for 0x06/0x07 and signed for 0x16/0x17.
- R4: Of the R3 forms, only opcode 0x06/0x07 with rs number 0 or rs number equal to rt number links; the unsigned two-register forms and all 0x16/0x17 forms do not.
- R5: Opcode 0x16 or 0x17 with rt number 0 raises `ri_exc_o`.
- R6: For opcodes 0x08 and 0x18: rs number >= rt number selects the overflow test (0x08 branches on overflow, 0x18 on no overflow); rs number 0 below rt number tests rt value == 0 (0x08) or != 0 (0x18) and links; otherwise rs value == rt value (0x08) or != (0x18) without link.
- R7: Overflow is true when either register value is not the sign extension of its low 32 bits, or when the 32-bit sum of the low halves has a sign different from both addends.
- R8: Opcodes 0x36/0x3E with rs number nonzero test rs value == 0 / != 0 with offset bits 20:0 shifted left 2 and sign-extended. With rs number 0 they always jump to rt value plus sign-extended imm16 (unshifted); 0x3E links.
- R9: Opcodes 0x32 and 0x3A always branch with offset bits 25:0 shifted left 2 and sign-extended; 0x3A links.
- R10: All other program-counter-relative targets are PC+4 plus imm16 shifted left 2 and sign-extended.
- R11: A compact branch with `in_dslot_i` set raises `ri_exc_o`; an exception always clears `taken_o` and `link_we_o`.
- R12: With `awrap_i` set and a datapath wider than 32 bits, the target is its low 32 bits sign-extended.
- R13: `link_val_o` is PC+4, and `link_we_o` stands for a write of it to register 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Word and operands present this cycle |
| insn_i | input | 32 | Instruction word |
| rs_val_i | input | XLEN | Value of register rs |
| rt_val_i | input | XLEN | Value of register rt |
| pc_i | input | XLEN | Address of the instruction |
| in_dslot_i | input | 1 | Word sits in a delay slot |
| awrap_i | input | 1 | Fold target into 32-bit range |
| out_valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| target_o | output | XLEN | Branch target, meaningful when taken |
| link_we_o | output | 1 | Write link value to register 31 |
| link_val_o | output | XLEN | Link value PC+4 |
| ri_exc_o | output | 1 | Reserved-instruction exception |
| not_cbr_o | output | 1 | Word is not a compact branch |

## Verification
The bench builds the block at its default 64-bit datapath width. That width makes the improperly sign-extended operand case of the overflow test and the address-wrap folding reachable, neither of which exists on a 32-bit build. Directed words cover each sub-form selection by register number, including the equal-number and zero-number corners, and a long run of mixed opcodes with biased register numbers fills in the rest against an independent model.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam logic [5:0] OP_LEZAL = 6'h06;
  localparam logic [5:0] OP_GTZAL = 6'h07;
  localparam logic [5:0] OP_OVEQ  = 6'h08;
  localparam logic [5:0] OP_LEZ   = 6'h16;
  localparam logic [5:0] OP_GTZ   = 6'h17;
  localparam logic [5:0] OP_NVNE  = 6'h18;
  localparam logic [5:0] OP_BR    = 6'h32;
  localparam logic [5:0] OP_JZ    = 6'h36;
  localparam logic [5:0] OP_BRL   = 6'h3A;
  localparam logic [5:0] OP_JNZ   = 6'h3E;

  typedef enum logic [4:0] {
    C_ALWAYS, C_LEZ, C_GTZ, C_GEZ, C_LTZ,
    C_GEU, C_LTU, C_GE, C_LT, C_EQ, C_NE,
    C_EQZ_RT, C_NEZ_RT, C_EQZ_RS, C_NEZ_RS, C_OV, C_NOV
  } cond_e;

  typedef enum logic [1:0] {
    O_I16, O_I21, O_I26, O_REG
  } off_e;

  typedef struct packed {
    logic  is_cb;
    logic  ri;
    logic  link;
    cond_e cond;
    off_e  off;
  } dec_t;
endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
  import cbr_pkg::*;
(
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  logic [5:0] op;
  logic [4:0] rsn, rtn;
  assign op  = insn_i[31:26];
  assign rsn = insn_i[25:21];
  assign rtn = insn_i[20:16];

  always_comb begin
    dec_o = '{is_cb: 1'b0, ri: 1'b0, link: 1'b0, cond: C_ALWAYS, off: O_I16};
    case (op)
      OP_LEZAL, OP_GTZAL: begin
        // rt==0 belongs to the delayed legacy form
        if (rtn != '0) begin
          dec_o.is_cb = 1'b1;
          if (rsn == '0) begin
            dec_o.link = 1'b1;
            dec_o.cond = (op == OP_LEZAL) ? C_LEZ : C_GTZ;
          end else if (rsn == rtn) begin
            dec_o.link = 1'b1;
            dec_o.cond = (op == OP_LEZAL) ? C_GEZ : C_LTZ;
          end else begin
            dec_o.cond = (op == OP_LEZAL) ? C_GEU : C_LTU;
          end
        end
      end
      OP_LEZ, OP_GTZ: begin
        dec_o.is_cb = 1'b1;
        if (rtn == '0) begin
          dec_o.ri = 1'b1;
        end else if (rsn == '0) begin
          dec_o.cond = (op == OP_LEZ) ? C_LEZ : C_GTZ;
        end else if (rsn == rtn) begin
          dec_o.cond = (op == OP_LEZ) ? C_GEZ : C_LTZ;
        end else begin
          dec_o.cond = (op == OP_LEZ) ? C_GE : C_LT;
        end
      end
      OP_OVEQ, OP_NVNE: begin
        dec_o.is_cb = 1'b1;
        if (rsn >= rtn) begin
          dec_o.cond = (op == OP_OVEQ) ? C_OV : C_NOV;
        end else if (rsn == '0) begin
          dec_o.link = 1'b1;
          dec_o.cond = (op == OP_OVEQ) ? C_EQZ_RT : C_NEZ_RT;
        end else begin
          dec_o.cond = (op == OP_OVEQ) ? C_EQ : C_NE;
        end
      end
      OP_BR, OP_BRL: begin
        dec_o.is_cb = 1'b1;
        dec_o.off   = O_I26;
        dec_o.link  = (op == OP_BRL);
      end
      OP_JZ, OP_JNZ: begin
        dec_o.is_cb = 1'b1;
        if (rsn != '0) begin
          dec_o.off  = O_I21;
          dec_o.cond = (op == OP_JZ) ? C_EQZ_RS : C_NEZ_RS;
        end else begin
          dec_o.off  = O_REG;
          dec_o.link = (op == OP_JNZ);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cbr_cond.sv
module cbr_cond
  import cbr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  cond_e           cond_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic            hit_o
);
  logic        rt_neg, rt_zero, rs_zero;
  logic        bad_rs, bad_rt, sum_ov, ov;
  logic [31:0] sum32;

  assign rt_neg  = rt_val_i[XLEN-1];
  assign rt_zero = (rt_val_i == '0);
  assign rs_zero = (rs_val_i == '0);

  generate
    if (XLEN > 32) begin : g_wide
      assign bad_rs = (rs_val_i[XLEN-1:32] != {(XLEN-32){rs_val_i[31]}});
      assign bad_rt = (rt_val_i[XLEN-1:32] != {(XLEN-32){rt_val_i[31]}});
    end else begin : g_narrow
      assign bad_rs = 1'b0;
      assign bad_rt = 1'b0;
    end
  endgenerate

  assign sum32  = rs_val_i[31:0] + rt_val_i[31:0];
  assign sum_ov = (sum32[31] ^ rs_val_i[31]) & (sum32[31] ^ rt_val_i[31]);
  assign ov     = bad_rs | bad_rt | sum_ov;

  always_comb begin
    case (cond_i)
      C_ALWAYS: hit_o = 1'b1;
      C_LEZ:    hit_o = rt_neg | rt_zero;
      C_GTZ:    hit_o = !rt_neg && !rt_zero;
      C_GEZ:    hit_o = !rt_neg;
      C_LTZ:    hit_o = rt_neg;
      C_GEU:    hit_o = (rs_val_i >= rt_val_i);
      C_LTU:    hit_o = (rs_val_i < rt_val_i);
      C_GE:     hit_o = ($signed(rs_val_i) >= $signed(rt_val_i));
      C_LT:     hit_o = ($signed(rs_val_i) < $signed(rt_val_i));
      C_EQ:     hit_o = (rs_val_i == rt_val_i);
      C_NE:     hit_o = (rs_val_i != rt_val_i);
      C_EQZ_RT: hit_o = rt_zero;
      C_NEZ_RT: hit_o = !rt_zero;
      C_EQZ_RS: hit_o = rs_zero;
      C_NEZ_RS: hit_o = !rs_zero;
      C_OV:     hit_o = ov;
      C_NOV:    hit_o = !ov;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbr_target.sv
module cbr_target
  import cbr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]     insn_i,
  input  off_e            off_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rt_val_i,
  input  logic            awrap_i,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] link_val_o
);
  localparam int INSN_BYTES = 4;

  logic [XLEN-1:0] pc_next, base, off, sum;

  assign pc_next    = pc_i + XLEN'(INSN_BYTES);
  assign link_val_o = pc_next;

  always_comb begin
    case (off_i)
      O_I21:   off = {{(XLEN-23){insn_i[20]}}, insn_i[20:0], 2'b00};
      O_I26:   off = {{(XLEN-28){insn_i[25]}}, insn_i[25:0], 2'b00};
      O_REG:   off = {{(XLEN-16){insn_i[15]}}, insn_i[15:0]};
      default: off = {{(XLEN-18){insn_i[15]}}, insn_i[15:0], 2'b00};
    endcase
  end

  assign base = (off_i == O_REG) ? rt_val_i : pc_next;
  assign sum  = base + off;

  generate
    if (XLEN > 32) begin : g_wrap
      assign target_o = awrap_i ? {{(XLEN-32){sum[31]}}, sum[31:0]} : sum;
    end else begin : g_nowrap
      logic unused_wrap;
      assign unused_wrap = awrap_i;
      assign target_o    = sum;
    end
  endgenerate
endmodule

// File: rtl/cbr_resolve.sv
module cbr_resolve
  import cbr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            in_dslot_i,
  input  logic            awrap_i,
  output logic            out_valid_o,
  output logic            taken_o,
  output logic [XLEN-1:0] target_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_val_o,
  output logic            ri_exc_o,
  output logic            not_cbr_o
);
  dec_t            dec;
  logic            hit, exc_d, taken_d, link_d;
  logic [XLEN-1:0] target_d, link_val_d;

  cbr_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  cbr_cond #(.XLEN(XLEN)) u_cond (
    .cond_i   (dec.cond),
    .rs_val_i (rs_val_i),
    .rt_val_i (rt_val_i),
    .hit_o    (hit)
  );

  cbr_target #(.XLEN(XLEN)) u_tgt (
    .insn_i     (insn_i),
    .off_i      (dec.off),
    .pc_i       (pc_i),
    .rt_val_i   (rt_val_i),
    .awrap_i    (awrap_i),
    .target_o   (target_d),
    .link_val_o (link_val_d)
  );

  assign exc_d   = dec.is_cb && (dec.ri || in_dslot_i);
  assign taken_d = dec.is_cb && !exc_d && hit;
  assign link_d  = dec.is_cb && !exc_d && dec.link;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      taken_o     <= 1'b0;
      link_we_o   <= 1'b0;
      ri_exc_o    <= 1'b0;
      not_cbr_o   <= 1'b0;
      target_o    <= '0;
      link_val_o  <= '0;
    end else begin
      out_valid_o <= valid_i;
      taken_o     <= valid_i && taken_d;
      link_we_o   <= valid_i && link_d;
      ri_exc_o    <= valid_i && exc_d;
      not_cbr_o   <= valid_i && !dec.is_cb;
      if (valid_i) begin
        target_o   <= target_d;
        link_val_o <= link_val_d;
      end
    end
  end

  p_out_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> out_valid_o);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !taken_o && !link_we_o && !ri_exc_o && !not_cbr_o);

  p_legacy_handoff_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && insn_i[31:26] == OP_LEZAL && insn_i[20:16] == 5'd0
    |=> not_cbr_o && !taken_o && !ri_exc_o && !link_we_o);

  p_zero_rt_ri_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && insn_i[31:26] == OP_GTZ && insn_i[20:16] == 5'd0 |=> ri_exc_o);

  p_jump_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && insn_i[31:26] == OP_JZ && insn_i[25:21] == 5'd0 && !in_dslot_i
    |=> taken_o && !link_we_o);

  p_balc_link_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && insn_i[31:26] == OP_BRL && !in_dslot_i
    |=> taken_o && link_we_o);

  p_dslot_exc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && in_dslot_i && dec.is_cb |=> ri_exc_o);

  p_exc_suppress_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ri_exc_o |-> !taken_o && !link_we_o && !not_cbr_o);

  p_link_value_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> link_val_o == $past(pc_i) + XLEN'(4));
endmodule

// File: tb/cbr_resolve_bench.sv
`timescale 1ns/1ps
module cbr_resolve_bench;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [W-1:0] rs_val = '0, rt_val = '0, pc = '0;
  logic         dslot = 1'b0, awrap = 1'b0;
  logic         out_valid, taken, link_we, ri_exc, not_cbr;
  logic [W-1:0] target, link_val;

  always #2 clk = ~clk;

  cbr_resolve #(.XLEN(W)) u_cbr_resolve (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn),
    .rs_val_i(rs_val), .rt_val_i(rt_val), .pc_i(pc),
    .in_dslot_i(dslot), .awrap_i(awrap),
    .out_valid_o(out_valid), .taken_o(taken), .target_o(target),
    .link_we_o(link_we), .link_val_o(link_val),
    .ri_exc_o(ri_exc), .not_cbr_o(not_cbr)
  );

  typedef struct {
    logic v, tk, lk, ex, nc;
    logic [W-1:0] tgt, lv;
    int cyc;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] sx32(input logic [31:0] x);
    return {{(W-32){x[31]}}, x};
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic exp_t model(input logic [31:0] w, input logic [W-1:0] a,
                                 input logic [W-1:0] b, input logic [W-1:0] p,
                                 input logic ds, input logic wr);
    exp_t e;
    logic [5:0] op;
    logic [4:0] rsn, rtn;
    logic cb, c, lk, ex, jump;
    logic [W-1:0] off, t;
    logic signed [W-1:0] s;
    logic ovf;
    op = w[31:26]; rsn = w[25:21]; rtn = w[20:16];
    cb = 1'b1; c = 1'b0; lk = 1'b0; ex = 1'b0; jump = 1'b0;
    off = {{(W-16){w[15]}}, w[15:0]} <<< 2;
    case (op)
      6'h06, 6'h07, 6'h16, 6'h17: begin
        if (rtn == 0 && (op == 6'h06 || op == 6'h07)) cb = 1'b0;
        else if (rtn == 0) ex = 1'b1;
        else if (rsn == 0) begin
          c = (op[0] == 1'b0) ? ($signed(b) <= 0) : ($signed(b) > 0);
          lk = (op[4] == 1'b0);
        end else if (rsn == rtn) begin
          c = (op[0] == 1'b0) ? ($signed(b) >= 0) : ($signed(b) < 0);
          lk = (op[4] == 1'b0);
        end else if (op[4] == 1'b0) c = (op[0] == 1'b0) ? (a >= b) : (a < b);
        else c = (op[0] == 1'b0) ? ($signed(a) >= $signed(b)) : ($signed(a) < $signed(b));
      end
      6'h08, 6'h18: begin
        if (rsn >= rtn) begin
          s = $signed(sx32(a[31:0])) + $signed(sx32(b[31:0]));
          ovf = (a != sx32(a[31:0])) || (b != sx32(b[31:0])) || (s != sx32(s[31:0]));
          c = (op == 6'h08) ? ovf : !ovf;
        end else if (rsn == 0) begin
          c = (op == 6'h08) ? (b == 0) : (b != 0); lk = 1'b1;
        end else c = (op == 6'h08) ? (a == b) : (a != b);
      end
      6'h32, 6'h3A: begin
        c = 1'b1; lk = (op == 6'h3A);
        off = {{(W-26){w[25]}}, w[25:0]} <<< 2;
      end
      6'h36, 6'h3E: begin
        if (rsn != 0) begin
          c = (op == 6'h36) ? (a == 0) : (a != 0);
          off = {{(W-21){w[20]}}, w[20:0]} <<< 2;
        end else begin
          c = 1'b1; jump = 1'b1; lk = (op == 6'h3E);
          off = {{(W-16){w[15]}}, w[15:0]};
        end
      end
      default: cb = 1'b0;
    endcase
    if (cb && ds) ex = 1'b1;
    t = jump ? (b + off) : (p + 4 + off);
    if (wr) t = sx32(t[31:0]);
    e.v = 1'b1; e.nc = !cb; e.ex = cb && ex;
    e.tk = cb && !ex && c; e.lk = cb && !ex && lk;
    e.tgt = t; e.lv = p + 4; e.cyc = 0; e.tag = "";
    return e;
  endfunction

  task automatic drive(input string tag, input logic [31:0] w, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [W-1:0] p,
                       input logic ds = 1'b0, input logic wr = 1'b0);
    exp_t e;
    @(negedge clk);
    valid = 1'b1; insn = w; rs_val = a; rt_val = b; pc = p; dslot = ds; awrap = wr;
    e = model(w, a, b, p, ds, wr);
    e.cyc = cyc; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    valid = 1'b0; insn = $urandom; rs_val = '1; rt_val = '0; dslot = 1'b1;
    e.v = 1'b0; e.tk = 1'b0; e.lk = 1'b0; e.ex = 1'b0; e.nc = 1'b0;
    e.tgt = '0; e.lv = '0; e.cyc = cyc; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: pops items driven in an earlier cycle
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
      exp_t e;
      bit bad;
      e = exp_q.pop_front();
      bad = (out_valid !== e.v) || (taken !== e.tk) || (link_we !== e.lk) ||
            (ri_exc !== e.ex) || (not_cbr !== e.nc) ||
            (e.tk && target !== e.tgt) || (e.lk && link_val !== e.lv);
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL %s: act v=%0b tk=%0b lk=%0b ex=%0b nc=%0b tgt=%h lv=%h exp v=%0b tk=%0b lk=%0b ex=%0b nc=%0b tgt=%h lv=%h",
                 e.tag, out_valid, taken, link_we, ri_exc, not_cbr, target, link_val,
                 e.v, e.tk, e.lk, e.ex, e.nc, e.tgt, e.lv);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: act running exp finished");
    finish_run();
  end

  function automatic string tag_of(input logic [5:0] op);
    case (op)
      6'h06, 6'h07, 6'h16, 6'h17: return "R3";
      6'h08, 6'h18: return "R6";
      6'h32, 6'h3A: return "R9";
      6'h36, 6'h3E: return "R8";
      default: return "R2";
    endcase
  endfunction

  initial begin
    logic [W-1:0] p0;
    logic [5:0] ops[12];
    p0 = 64'h0000_0000_0040_1000;
    ops = '{6'h06, 6'h07, 6'h08, 6'h16, 6'h17, 6'h18, 6'h32, 6'h36, 6'h3A, 6'h3E, 6'h00, 6'h23};
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || taken !== 1'b0 || link_we !== 1'b0 || ri_exc !== 1'b0 || not_cbr !== 1'b0) begin
      errors++;
      $display("FAIL R1: act v=%0b tk=%0b lk=%0b ex=%0b nc=%0b exp all 0",
               out_valid, taken, link_we, ri_exc, not_cbr);
    end
    rst_n = 1'b1;
    idle("R1");
    // R2: hand-off to legacy decoder
    drive("R2", mk(6'h06, 5'd3, 5'd0, 16'h0010), 64'd1, 64'd0, p0);
    drive("R2", mk(6'h07, 5'd0, 5'd0, 16'h0010), 64'd1, 64'd0, p0);
    drive("R2", mk(6'h00, 5'd1, 5'd2, 16'h0000), 64'd1, 64'd0, p0);
    // R3/R4: zero compare with link, equal-number form, unsigned vs signed
    drive("R3", mk(6'h06, 5'd0, 5'd5, 16'h0004), 64'd0, -64'sd3, p0);
    drive("R3", mk(6'h06, 5'd0, 5'd5, 16'h0004), 64'd0, 64'd7, p0);
    drive("R4", mk(6'h07, 5'd4, 5'd4, 16'hFFF0), -64'sd1, -64'sd1, p0);
    drive("R3", mk(6'h07, 5'd4, 5'd4, 16'hFFF0), 64'd0, 64'd0, p0);
    drive("R4", mk(6'h06, 5'd3, 5'd5, 16'h0020), -64'sd1, 64'd1, p0);
    drive("R3", mk(6'h16, 5'd3, 5'd5, 16'h0020), -64'sd1, 64'd1, p0);
    drive("R3", mk(6'h17, 5'd3, 5'd5, 16'h0020), -64'sd1, 64'd1, p0);
    drive("R4", mk(6'h16, 5'd0, 5'd5, 16'h0020), 64'd0, 64'd0, p0);
    // R5
    drive("R5", mk(6'h16, 5'd7, 5'd0, 16'h0020), 64'd0, 64'd0, p0);
    drive("R5", mk(6'h17, 5'd0, 5'd0, 16'h0020), 64'd0, 64'd0, p0);
    // R6
    drive("R6", mk(6'h08, 5'd5, 5'd3, 16'h0008), 64'h7FFF_FFFF, 64'd1, p0);
    drive("R6", mk(6'h18, 5'd5, 5'd3, 16'h0008), 64'h7FFF_FFFF, 64'd1, p0);
    drive("R6", mk(6'h08, 5'd0, 5'd3, 16'h0008), 64'd9, 64'd0, p0);
    drive("R6", mk(6'h18, 5'd0, 5'd3, 16'h0008), 64'd9, 64'd0, p0);
    drive("R6", mk(6'h18, 5'd2, 5'd9, 16'h0008), 64'd44, 64'd44, p0);
    drive("R6", mk(6'h18, 5'd2, 5'd9, 16'h0008), 64'd44, 64'd45, p0);
    drive("R6", mk(6'h08, 5'd2, 5'd9, 16'h0008), 64'd44, 64'd44, p0);
    // R7: overflow corners
    drive("R7", mk(6'h08, 5'd6, 5'd6, 16'h0008), 64'h1_0000_0000, 64'd0, p0);
    drive("R7", mk(6'h08, 5'd6, 5'd1, 16'h0008), sx32(32'h8000_0000), -64'sd1, p0);
    drive("R7", mk(6'h08, 5'd6, 5'd1, 16'h0008), -64'sd1, -64'sd1, p0);
    drive("R7", mk(6'h18, 5'd6, 5'd1, 16'h0008), 64'd5, 64'h0000_0001_0000_0000, p0);
    // R8
    drive("R8", mk(6'h36, 5'd4, 5'h1F, 16'hFFF8), 64'd0, 64'd0, p0);
    drive("R8", mk(6'h3E, 5'd4, 5'h10, 16'h0003), 64'd2, 64'd0, p0);
    drive("R8", mk(6'h36, 5'd0, 5'd7, 16'hFFFC), 64'd0, 64'h1000, p0);
    drive("R8", mk(6'h3E, 5'd0, 5'd7, 16'h0011), 64'd0, 64'h2000, p0);
    // R9
    drive("R9", {6'h32, 26'h3FF_FFF0}, 64'd0, 64'd0, p0);
    drive("R9", {6'h3A, 26'h200_0001}, 64'd0, 64'd0, p0);
    drive("R9", {6'h3A, 26'h000_0040}, 64'd0, 64'd0, p0);
    // R10
    drive("R10", mk(6'h17, 5'd0, 5'd2, 16'h8000), 64'd0, 64'd1, p0);
    idle("R1");
    // R11
    drive("R11", {6'h3A, 26'h000_0040}, 64'd0, 64'd0, p0, 1'b1);
    drive("R11", mk(6'h06, 5'd0, 5'd5, 16'h0004), 64'd0, -64'sd3, p0, 1'b1);
    drive("R11", mk(6'h00, 5'd0, 5'd5, 16'h0004), 64'd0, 64'd0, p0, 1'b1);
    // R12
    drive("R12", mk(6'h32, 5'd0, 5'd0, 16'h0010), 64'd0, 64'd0, 64'h7FFF_FFF0, 1'b0, 1'b1);
    drive("R12", mk(6'h32, 5'd0, 5'd0, 16'h0010), 64'd0, 64'd0, 64'h7FFF_FFF0, 1'b0, 1'b0);
    drive("R12", mk(6'h36, 5'd0, 5'd1, 16'h0000), 64'd0, 64'h1_2345_6780, p0, 1'b0, 1'b1);
    // R13
    drive("R13", mk(6'h3E, 5'd0, 5'd1, 16'h0000), 64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFC);
    // mixed run
    for (int i = 0; i < 600; i++) begin
      logic [5:0] op;
      logic [4:0] rsn, rtn;
      logic [W-1:0] a, b;
      op  = ops[$urandom_range(0, 11)];
      rsn = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom_range(0, 31));
      rtn = ($urandom_range(0, 3) == 0) ? rsn : 5'($urandom_range(0, 31));
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom_range(0, 2) != 0) a = sx32(a[31:0]);
      if ($urandom_range(0, 2) != 0) b = sx32(b[31:0]);
      if ($urandom_range(0, 5) == 0) a = '0;
      if ($urandom_range(0, 5) == 0) b = '0;
      drive(tag_of(op), {op, rsn, rtn, 16'($urandom)}, a, b,
            {$urandom, $urandom[31:2], 2'b00},
            ($urandom_range(0, 7) == 0), ($urandom_range(0, 3) == 0));
      if ($urandom_range(0, 9) == 0) idle("R1");
    end
    idle("R1");
    idle("R1");
    @(negedge clk);
    @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1: act pending=%0d exp 0", exp_q.size());
    end
    finish_run();
  end
endmodule